// File: doc/BRIEF.md
# Output Channel Acknowledge and Timeout Tracker

This block governs transmission on a single outgoing link that uses credit flow control with exactly one credit. When the channel is idle, a flit may be launched. After that the channel holds no credit until the neighbour downstream returns an acknowledge. A small down-counter watches the wait. If no acknowledge arrives before the counter runs out, the channel enters a timed-out state.

The downstream node may instead answer that it has already taken the same message. In that case the channel refuses to send any more flits of the current packet. Both the blocked state and the timed-out state are reported upward on a 2-bit status so that the node controller can react for fault tolerance. Both states hold until the controller pulses new-packet. Data movement on the link and any retry decision belong to the surrounding logic.

Top module: `ocat_chan_tracker`

## Requirements
- R1: After reset the status output is 2'b00 (idle, last flit acknowledged).
- R2: can_send_o equals send_req_i while the status is idle (2'b00), and it is 0 in every other state.
- R3: A flit_sent_i strobe sampled in the idle state moves the status to waiting (2'b11) at that clock edge. A flit_sent_i strobe in any other state is ignored.
- R4: An ack_i sampled while waiting returns the status to idle (2'b00), which restores the single credit.
- R5: An acked_i sampled while waiting with no ack_i moves the status to blocked (2'b01). If ack_i and acked_i are sampled together, ack_i wins.
- R6: Each send loads the timer with 2**TIMER_W-1 (15 for 4 bits). If no ack_i or acked_i arrives at the 2**TIMER_W (16) edges that follow the send edge, the status becomes timed out (2'b10) at the 16th edge. An ack_i at the 16th edge still returns the status to idle.
- R7: Blocked and timed-out states hold through ack_i, acked_i and flit_sent_i. Only a new_pkt_i pulse returns the status to idle, at the edge where it is sampled.
- R8: new_pkt_i has no effect in the idle and waiting states.
- R9: Every send reloads the full timer, so a later flit gets a complete timeout window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| send_req_i | input | 1 | Upstream logic has a flit ready for this channel |
| flit_sent_i | input | 1 | Strobe: a flit went out on the link this cycle |
| ack_i | input | 1 | Strobe: downstream acknowledged the last flit |
| acked_i | input | 1 | Strobe: downstream already holds this message |
| new_pkt_i | input | 1 | Pulse: start of a new packet, clears blocked or timed-out |
| can_send_o | output | 1 | Sending is permitted this cycle |
| status_o | output | 2 | 00 idle, 01 blocked, 10 timed out, 11 waiting |

## Verification
can_send_o is combinational, so it is due in the same cycle that send_req_i or the state changes. A status change is due one edge after the strobe that causes it. The timeout is due exactly 16 edges after the send edge. The bench drives inputs on falling edges and samples after the next falling edge, so each check sees the result of exactly one rising edge. The bench sweeps acknowledge and already-acknowledged delays from 1 to 17 cycles, which covers both sides of the timeout boundary. It checks every status value in each of those cycles.

// File: rtl/ocat_pkg.sv
package ocat_pkg;
  // Encoded channel status; the encoding is visible on status_o.
  typedef enum logic [1:0] {
    CH_IDLE    = 2'b00,
    CH_BLOCKED = 2'b01,
    CH_TIMEOUT = 2'b10,
    CH_WAIT    = 2'b11
  } ch_state_e;
endpackage

// File: rtl/ocat_timer.sv
module ocat_timer #(
  parameter int TIMER_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);
  localparam logic [TIMER_W-1:0] TMAX = {TIMER_W{1'b1}};

  logic [TIMER_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = cnt_q;
    if (load_i)     cnt_d = TMAX;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ocat_fsm.sv
module ocat_fsm
  import ocat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flit_sent_i,
  input  logic      ack_i,
  input  logic      acked_i,
  input  logic      new_pkt_i,
  input  logic      tmr_zero_i,
  output logic      tmr_load_o,
  output logic      tmr_dec_o,
  output ch_state_e state_o
);
  ch_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_dec_o  = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (flit_sent_i) begin
          state_d    = CH_WAIT;
          tmr_load_o = 1'b1;
        end
      end
      CH_WAIT: begin
        if (ack_i)           state_d = CH_IDLE;
        else if (acked_i)    state_d = CH_BLOCKED;
        else if (tmr_zero_i) state_d = CH_TIMEOUT;
        else                 tmr_dec_o = 1'b1;
      end
      CH_BLOCKED, CH_TIMEOUT: begin
        if (new_pkt_i) state_d = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ocat_chan_tracker.sv
module ocat_chan_tracker #(
  parameter int TIMER_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_req_i,
  input  logic       flit_sent_i,
  input  logic       ack_i,
  input  logic       acked_i,
  input  logic       new_pkt_i,
  output logic       can_send_o,
  output logic [1:0] status_o
);
  import ocat_pkg::*;

  logic      tmr_load, tmr_dec, tmr_zero;
  ch_state_e state;

  ocat_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flit_sent_i(flit_sent_i),
    .ack_i      (ack_i),
    .acked_i    (acked_i),
    .new_pkt_i  (new_pkt_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_dec_o  (tmr_dec),
    .state_o    (state)
  );

  ocat_timer #(.TIMER_W(TIMER_W)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .dec_i (tmr_dec),
    .zero_o(tmr_zero)
  );

  assign can_send_o = send_req_i & (state == CH_IDLE);
  assign status_o   = state;
endmodule

// File: rtl/ocat_chan_tracker_chk.sv
module ocat_chan_tracker_chk #(
  parameter int TIMER_W = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       send_req_i,
  input logic       flit_sent_i,
  input logic       ack_i,
  input logic       acked_i,
  input logic       new_pkt_i,
  input logic       can_send_o,
  input logic [1:0] status_o
);
  localparam int          CW   = TIMER_W + 1;
  localparam logic [CW-1:0] TLIM = CW'((1 << TIMER_W) - 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_cnt <= '0;
    else if (status_o == 2'b11) wait_cnt <= wait_cnt + 1'b1;
    else                        wait_cnt <= '0;
  end

  // R2
  can_send_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    can_send_o |-> (status_o == 2'b00 && send_req_i));
  // R3
  send_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b00 && flit_sent_i) |=> status_o == 2'b11);
  // R4
  ack_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b11 && ack_i) |=> status_o == 2'b00);
  // R5
  acked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b11 && !ack_i && acked_i) |=> status_o == 2'b01);
  // R6
  timeout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b11 && !ack_i && !acked_i && wait_cnt == TLIM) |=> status_o == 2'b10);
  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b11) |-> wait_cnt <= TLIM);
  // R7
  hold_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] != status_o[0] && !new_pkt_i) |=> $stable(status_o));
  // R7
  new_pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] != status_o[0] && new_pkt_i) |=> status_o == 2'b00);
endmodule

bind ocat_chan_tracker ocat_chan_tracker_chk #(.TIMER_W(TIMER_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .send_req_i (send_req_i),
  .flit_sent_i(flit_sent_i),
  .ack_i      (ack_i),
  .acked_i    (acked_i),
  .new_pkt_i  (new_pkt_i),
  .can_send_o (can_send_o),
  .status_o   (status_o)
);

// File: tb/ocat_chan_tracker_tb_top.sv
module ocat_chan_tracker_tb_top;
  localparam int TW   = 4;
  localparam int WIN  = 1 << TW;   // edges until timeout
  localparam logic [1:0] S_IDLE = 2'b00, S_BLK = 2'b01, S_TO = 2'b10, S_WAIT = 2'b11;

  logic clk = 1'b0;
  logic rst_n, send_req, flit_sent, ack, acked, new_pkt;
  logic can_send;
  logic [1:0] status;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  ocat_chan_tracker #(.TIMER_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_req_i(send_req), .flit_sent_i(flit_sent),
    .ack_i(ack), .acked_i(acked), .new_pkt_i(new_pkt),
    .can_send_o(can_send), .status_o(status)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    flit_sent = 0; ack = 0; acked = 0; new_pkt = 0;
  endtask

  task automatic send_flit();
    flit_sent = 1; tick(); flit_sent = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; send_req = 1; clear_in();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1", status, S_IDLE);
    check("R2", {1'b0, can_send}, 2'b01);
    send_req = 0; #1;
    check("R2", {1'b0, can_send}, 2'b00);
    send_req = 1;
    // R8 new_pkt in idle ignored
    new_pkt = 1; tick(); new_pkt = 0;
    check("R8", status, S_IDLE);

    // ack delay sweep: R3, R4, R6, R9
    for (int d = 1; d <= WIN + 1; d++) begin
      send_flit();
      check("R3", status, S_WAIT);
      check("R2", {1'b0, can_send}, 2'b00);
      for (int k = 1; k < d; k++) begin
        if (k == 3) begin new_pkt = 1; flit_sent = 1; end   // R8 R3 ignored while waiting
        tick();
        new_pkt = 0; flit_sent = 0;
        check("R6", status, (k >= WIN) ? S_TO : S_WAIT);
      end
      ack = 1; tick(); ack = 0;
      if (d <= WIN) check("R4", status, S_IDLE);
      else begin
        check("R7", status, S_TO);
        new_pkt = 1; tick(); new_pkt = 0;
        check("R7", status, S_IDLE);
      end
    end

    // already-acknowledged delay sweep: R5, R7
    for (int d = 1; d <= WIN + 1; d++) begin
      send_flit();
      for (int k = 1; k < d; k++) tick();
      acked = 1; tick(); acked = 0;
      check("R5", status, (d <= WIN) ? S_BLK : S_TO);
      check("R2", {1'b0, can_send}, 2'b00);
      ack = 1; flit_sent = 1; acked = 1; tick(); clear_in();
      check("R7", status, (d <= WIN) ? S_BLK : S_TO);
      tick(); tick();
      check("R7", status, (d <= WIN) ? S_BLK : S_TO);
      new_pkt = 1; tick(); new_pkt = 0;
      check("R7", status, S_IDLE);
    end

    // R5 ack beats acked
    send_flit();
    ack = 1; acked = 1; tick(); clear_in();
    check("R5", status, S_IDLE);

    // R9 back-to-back windows each get full length
    for (int r = 0; r < 2; r++) begin
      send_flit();
      for (int k = 1; k < WIN; k++) tick();
      check("R9", status, S_WAIT);
      tick();
      check("R9", status, S_TO);
      new_pkt = 1; tick(); new_pkt = 0;
    end

    // R4 ack in idle ignored
    ack = 1; tick(); ack = 0;
    check("R4", status, S_IDLE);

    // R1 reset mid-wait
    send_flit();
    rst_n = 0; tick();
    check("R1", status, S_IDLE);
    rst_n = 1; tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule